// File: doc/BRIEF.md
# General-Purpose Pin Register Bank

This block is a memory-mapped controller for a bank of general-purpose pins, 94 by default. A 32-bit register port with a single request strobe reads and writes the bank. The bank holds an ownership bitmap that spans all pins, one global control word, and two configuration words for each pin. From that state the block drives an output value and an output enable onto every pin. It also samples every pin input through a synchroniser.

Configuration word 1 of a pin holds four things: the level the pin drives, the live sampled input level, the direction and the function select. Configuration word 2 holds the input-sense disable and a two-bit weak-pull code. A pin drives its pad only when the GPIO function is selected and the direction is output. In every other case the pad is released.

Interrupt detection is handled by a separate block, so the offsets it would use read as zero here. Firmware uses the ownership bitmap: a 0 in a pin's bit reserves that pin for firmware.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: The ownership bitmap sits in words at 0x00, 0x04 and 0x08. Pin n is bit n%32 of the word at (n/32)*4. The global word at 0x7C is a full 32-bit read/write register. Both are writable and read back what was written.
- R2: Configuration word 1 of pin n is at 0x100+8*n and word 2 is at 0x104+8*n. The last pin's word 2 (0x3EC by default) is mapped and the next offset (0x3F0) is not.
- R3: In configuration word 1, bit 31 is the driven level (read/write). Bit 2 is the direction: 0 makes the pin an output, 1 makes it an input. Bit 0 is the function: 0 native, 1 GPIO. Every other bit except bit 30 reads 0.
- R4: Bit 30 of configuration word 1 reads the synchronised input level. Writes to bit 30 have no effect.
- R5: In configuration word 2, bit 2 disables input sensing and bits 1:0 are the weak-pull code. All other bits read 0.
- R6: pin_oe of a pin is 1 exactly when its function bit is 1 and its direction bit is 0. pin_out carries the driven level while pin_oe is 1 and is 0 otherwise.
- R7: A pin input reaches bit 30 through two flops. A read captured at the first or second clock edge after the input changes returns the old level. A read captured at the third edge returns the new level.
- R8: While input sensing is disabled, bit 30 reads 0 whatever the pin input is.
- R9: After reset the ownership bitmap equals the OWN_INIT parameter and the global word equals GLOBAL_INIT (0x0000000E by default). Every pin resets to word 1 = 0x00000005 (GPIO function, input, level 0) and word 2 = 0x00000004 (sensing disabled, pull 0), with all pins released.
- R10: Reads of unmapped offsets return 0. This includes 0x0C to 0x78, 0x80, 0x90 and everything beyond the last pin's words. Writes to unmapped offsets change no state.
- R11: bus_rdata is loaded at the clock edge that accepts a read (bus_en=1, bus_we=0). It holds its value at every other edge, writes included.
- R12: Ownership bits above the last pin (bits 30 and 31 of word 0x08 by default) read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W (12) | Byte address; the low two bits are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | NUM_PINS (94) | Asynchronous pin inputs |
| pin_out | output | NUM_PINS (94) | Driven pin levels |
| pin_oe | output | NUM_PINS (94) | Pin output enables |

## Verification
A wrong configuration bit shows up on pin_oe or pin_out on the cycle right after the write that sets it. The fault persists until the next write to that pin, so every mode check reads the pins at once. A decode fault either aliases pins or lets a write leak into an unmapped offset. That shows up on the next read-back of a neighbouring pin or word, so the tests write distinct patterns to adjacent and boundary offsets before reading them. A synchroniser depth error moves bit 30 by one cycle, and only back-to-back reads around an input change can see it.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam logic [31:0] GLOBAL_OFS = 32'h0000_007C;
  localparam logic [31:0] CFG_BASE   = 32'h0000_0100;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_OWN,
    RK_GLOBAL,
    RK_CFG1,
    RK_CFG2
  } reg_kind_e;

  typedef struct packed {
    logic       out_lvl;
    logic       dir_in;
    logic       gpio_sel;
    logic       sense_off;
    logic [1:0] pull;
  } pin_cfg_t;

  localparam pin_cfg_t PIN_CFG_RESET = '{
    out_lvl: 1'b0, dir_in: 1'b1, gpio_sel: 1'b1, sense_off: 1'b1, pull: 2'b00
  };

  // Classify a byte address; low two bits do not take part.
  function automatic reg_kind_e decode_kind(input logic [31:0] a, input logic [31:0] npins);
    logic [31:0] word_a;
    logic [31:0] nwords;
    word_a = a >> 2;
    nwords = (npins + 32'd31) >> 5;
    if (word_a < nwords) return RK_OWN;
    if (word_a == (GLOBAL_OFS >> 2)) return RK_GLOBAL;
    if (a >= CFG_BASE && ((a - CFG_BASE) >> 3) < npins) return a[2] ? RK_CFG2 : RK_CFG1;
    return RK_NONE;
  endfunction

  function automatic logic [31:0] pack_cfg1(input pin_cfg_t c, input logic in_lvl);
    return {c.out_lvl, in_lvl, 27'd0, c.dir_in, 1'b0, c.gpio_sel};
  endfunction

  function automatic logic [31:0] pack_cfg2(input pin_cfg_t c);
    return {29'd0, c.sense_off, c.pull};
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 94
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_own_regs.sv
module gpio_own_regs #(
  parameter int                  NUM_PINS  = 94,
  parameter int                  OWN_WORDS = 3,
  parameter int                  IDX_W     = 2,
  parameter logic [NUM_PINS-1:0] INIT      = '1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         word_idx,
  input  logic [31:0]              wdata,
  output logic [OWN_WORDS*32-1:0]  own_ext
);
  logic [NUM_PINS-1:0] own_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= INIT;
    end else if (wr_en) begin
      for (int b = 0; b < NUM_PINS; b++) begin
        if (word_idx == IDX_W'(b / 32)) own_q[b] <= wdata[b % 32];
      end
    end
  end

  // Bits above the last pin are not stored and read as zero.
  assign own_ext = (OWN_WORDS*32)'(own_q);
endmodule

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg
  import gpio_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_word1,
  input  logic        wr_word2,
  input  logic [31:0] wdata,
  output pin_cfg_t    cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= PIN_CFG_RESET;
    end else if (wr_word1) begin
      cfg.out_lvl  <= wdata[31];
      cfg.dir_in   <= wdata[2];
      cfg.gpio_sel <= wdata[0];
    end else if (wr_word2) begin
      cfg.sense_off <= wdata[2];
      cfg.pull      <= wdata[1:0];
    end
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int                  NUM_PINS    = 94,
  parameter int                  ADDR_W      = 12,
  parameter logic [NUM_PINS-1:0] OWN_INIT    = '1,
  parameter logic [31:0]         GLOBAL_INIT = 32'h0000_000E
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  localparam int OWN_WORDS = (NUM_PINS + 31) / 32;
  localparam int OWN_IDX_W = (OWN_WORDS > 1) ? $clog2(OWN_WORDS) : 1;
  localparam int PIN_W     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  // Decoded access, brought out for the checker.
  reg_kind_e              kind;
  logic [ADDR_W-1:0]      cfg_off;
  logic [PIN_W-1:0]       pin_idx;
  logic [OWN_IDX_W-1:0]   own_idx;
  logic                   rd_req;
  logic                   wr_req;
  logic                   wr_cfg1_hit;
  logic                   wr_cfg2_hit;
  logic                   rd_cfg1_hit;
  logic                   rd_none_hit;

  assign kind        = decode_kind(32'(bus_addr), 32'(NUM_PINS));
  assign cfg_off     = bus_addr - ADDR_W'(CFG_BASE);
  assign pin_idx     = PIN_W'(cfg_off >> 3);
  assign own_idx     = OWN_IDX_W'(bus_addr >> 2);
  assign rd_req      = bus_en && !bus_we;
  assign wr_req      = bus_en && bus_we;
  assign wr_cfg1_hit = wr_req && (kind == RK_CFG1);
  assign wr_cfg2_hit = wr_req && (kind == RK_CFG2);
  assign rd_cfg1_hit = rd_req && (kind == RK_CFG1);
  assign rd_none_hit = rd_req && (kind == RK_NONE);

  // Ownership bitmap.
  logic [OWN_WORDS*32-1:0] own_ext;
  gpio_own_regs #(
    .NUM_PINS (NUM_PINS),
    .OWN_WORDS(OWN_WORDS),
    .IDX_W    (OWN_IDX_W),
    .INIT     (OWN_INIT)
  ) u_own (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_req && (kind == RK_OWN)),
    .word_idx(own_idx),
    .wdata   (bus_wdata),
    .own_ext (own_ext)
  );

  // Global control word.
  logic [31:0] global_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) global_q <= GLOBAL_INIT;
    else if (wr_req && (kind == RK_GLOBAL)) global_q <= bus_wdata;
  end

  // Input synchroniser.
  logic [NUM_PINS-1:0] pin_sync;
  gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(pin_in),
    .sync_out(pin_sync)
  );

  // Per-pin configuration and pad drive.
  pin_cfg_t            cfg_q [NUM_PINS];
  logic [NUM_PINS-1:0] sense_off_vec;
  logic [NUM_PINS-1:0] in_lvl;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_pin_cfg u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_word1(wr_cfg1_hit && (pin_idx == PIN_W'(p))),
      .wr_word2(wr_cfg2_hit && (pin_idx == PIN_W'(p))),
      .wdata   (bus_wdata),
      .cfg     (cfg_q[p])
    );
    assign sense_off_vec[p] = cfg_q[p].sense_off;
    assign in_lvl[p]        = pin_sync[p] && !cfg_q[p].sense_off;
    assign pin_oe[p]        = cfg_q[p].gpio_sel && !cfg_q[p].dir_in;
    assign pin_out[p]       = pin_oe[p] && cfg_q[p].out_lvl;
  end

  // Read path.
  logic [31:0] rd_word;
  always_comb begin
    unique case (kind)
      RK_OWN:    rd_word = own_ext[32*own_idx +: 32];
      RK_GLOBAL: rd_word = global_q;
      RK_CFG1:   rd_word = pack_cfg1(cfg_q[pin_idx], in_lvl[pin_idx]);
      RK_CFG2:   rd_word = pack_cfg2(cfg_q[pin_idx]);
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (rd_req) bus_rdata <= rd_word;
  end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int NUM_PINS = 94,
  parameter int PIN_W    = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rd_req,
  input logic                wr_cfg1_hit,
  input logic                rd_cfg1_hit,
  input logic                rd_none_hit,
  input logic [PIN_W-1:0]    pin_idx,
  input logic [31:0]         bus_wdata,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PINS-1:0] sense_off_vec,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe
);
  // R6: a write selecting GPIO output enables that pin on the next cycle
  a_r6_drive_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg1_hit && bus_wdata[0] && !bus_wdata[2]) |=> pin_oe[$past(pin_idx)]);

  // R6: a write selecting input direction releases the pin
  a_r6_release_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg1_hit && bus_wdata[2]) |=> !pin_oe[$past(pin_idx)]);

  // R6: a released pin never drives a high level
  a_r6_quiet_when_released: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & ~pin_oe) == '0));

  // R8: sensing disabled forces the input bit low
  a_r8_sense_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cfg1_hit && sense_off_vec[pin_idx]) |=> !bus_rdata[30]);

  // R10: unmapped reads return zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_none_hit |=> (bus_rdata == 32'd0));

  // R11: read data holds when no read is accepted
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(bus_rdata));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
  .NUM_PINS(NUM_PINS),
  .PIN_W   (PIN_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_req       (rd_req),
  .wr_cfg1_hit  (wr_cfg1_hit),
  .rd_cfg1_hit  (rd_cfg1_hit),
  .rd_none_hit  (rd_none_hit),
  .pin_idx      (pin_idx),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .sense_off_vec(sense_off_vec),
  .pin_out      (pin_out),
  .pin_oe       (pin_oe)
);

// File: tb/test_gpio_bank_ctrl.sv
module test_gpio_bank_ctrl;
  localparam int NP = 94;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_en = 1'b0;
  logic          bus_we = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio_bank_ctrl i_gpio_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [11:0] a_cfg1(input int p);
    return 12'(32'h100 + 8 * p);
  endfunction
  function automatic logic [11:0] a_cfg2(input int p);
    return 12'(32'h104 + 8 * p);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // All bus tasks start and end just after a falling edge.
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(12'h000, d); check("R9 own word0", d, 32'hFFFF_FFFF);
    rd(12'h008, d); check("R12 own word2 upper bits", d, 32'h3FFF_FFFF);
    rd(12'h07C, d); check("R9 global", d, 32'h0000_000E);
    rd(a_cfg1(0), d); check("R9 cfg1 pin0", d, 32'h0000_0005);
    rd(a_cfg2(93), d); check("R9 cfg2 pin93", d, 32'h0000_0004);
    check("R9 pins released", 32'(pin_oe != '0), 32'd0);
  endtask

  task automatic t_own_global;
    logic [31:0] d;
    wr(12'h004, 32'hA5A5_1234);
    rd(12'h004, d); check("R1 own word1", d, 32'hA5A5_1234);
    rd(12'h000, d); check("R1 own word0 untouched", d, 32'hFFFF_FFFF);
    wr(12'h008, 32'h0000_0000);
    wr(12'h008, 32'hFFFF_FFFF);
    rd(12'h008, d); check("R12 own top bits ignored", d, 32'h3FFF_FFFF);
    wr(12'h07C, 32'hDEAD_BEEF);
    rd(12'h07C, d); check("R1 global rw", d, 32'hDEAD_BEEF);
  endtask

  task automatic t_cfg_modes;
    logic [31:0] d;
    wr(a_cfg1(7), 32'h8000_0001);
    check("R6 pin7 oe", 32'(pin_oe[7]), 32'd1);
    check("R6 pin7 out", 32'(pin_out[7]), 32'd1);
    rd(a_cfg1(7), d); check("R3 cfg1 pin7", d, 32'h8000_0001);
    wr(a_cfg1(93), 32'hFFFF_FFFF);
    rd(a_cfg1(93), d); check("R3 cfg1 unused bits zero", d, 32'h8000_0005);
    check("R6 pin93 input released", 32'(pin_oe[93]), 32'd0);
    check("R6 pin93 out low", 32'(pin_out[93]), 32'd0);
    wr(a_cfg2(7), 32'hFFFF_FFFB);
    rd(a_cfg2(7), d); check("R5 cfg2 fields", d, 32'h0000_0003);
    wr(a_cfg1(7), 32'h8000_0000);
    check("R6 native releases", 32'(pin_oe[7]), 32'd0);
    check("R6 native out low", 32'(pin_out[7]), 32'd0);
    wr(a_cfg1(7), 32'h0000_0001);
    check("R6 driving low", 32'({pin_oe[7], pin_out[7]}), 32'd2);
  endtask

  task automatic t_layout;
    logic [31:0] d;
    wr(12'h108, 32'h8000_0001);
    check("R2 pin1 enabled", 32'(pin_oe[1]), 32'd1);
    check("R2 pin0 untouched", 32'(pin_oe[0]), 32'd0);
    wr(12'h3EC, 32'h0000_0001);
    rd(12'h3EC, d); check("R2 last pin cfg2", d, 32'h0000_0001);
    rd(12'h3E8, d); check("R2 last pin cfg1", d, 32'h8000_0005);
  endtask

  task automatic t_sync;
    logic [31:0] d;
    wr(a_cfg2(12), 32'h0);
    pin_in[12] = 1'b1;
    rd(a_cfg1(12), d); check("R7 first edge old", d, 32'h0000_0005);
    rd(a_cfg1(12), d); check("R7 second edge old", d, 32'h0000_0005);
    rd(a_cfg1(12), d); check("R7 third edge new", d, 32'h4000_0005);
    wr(a_cfg2(12), 32'h4);
    rd(a_cfg1(12), d); check("R8 sense off reads low", d, 32'h0000_0005);
    wr(a_cfg2(12), 32'h0);
    pin_in[12] = 1'b0;
    repeat (3) @(negedge clk);
    wr(a_cfg1(12), 32'h4000_0005);
    rd(a_cfg1(12), d); check("R4 bit30 write ignored", d, 32'h0000_0005);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(12'h080, 32'hFFFF_FFFF);
    wr(12'h090, 32'hFFFF_FFFF);
    wr(12'h00C, 32'h0000_0000);
    wr(12'h3F0, 32'h0000_0000);
    wr(12'h3F4, 32'h0000_0000);
    rd(12'h080, d); check("R10 offset 0x80", d, 32'h0);
    rd(12'h090, d); check("R10 offset 0x90", d, 32'h0);
    rd(12'h00C, d); check("R10 offset 0x0C", d, 32'h0);
    rd(12'h3F0, d); check("R10 past last pin", d, 32'h0);
    rd(12'h000, d); check("R10 own word0 unchanged", d, 32'hFFFF_FFFF);
    rd(12'h3E8, d); check("R10 pin93 cfg1 unchanged", d, 32'h8000_0005);
    rd(12'h3EC, d); check("R10 pin93 cfg2 unchanged", d, 32'h0000_0001);
  endtask

  task automatic t_hold;
    logic [31:0] d;
    rd(12'h07C, d);
    wr(12'h07C, 32'h1234_5678);
    repeat (2) @(negedge clk);
    check("R11 rdata held across write and idle", bus_rdata, 32'hDEAD_BEEF);
    rd(12'h07C, d); check("R11 rdata loads on read", d, 32'h1234_5678);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_own_global();
    t_cfg_modes();
    t_layout();
    t_sync();
    t_unmapped();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule